// File: doc/BRIEF.md
# Terminal-Value Wrap Counter

This block is a library counter cell. It steps a register once per advance and wraps at a terminal value that is set by a parameter. It can count downward, from the terminal value to zero, or upward, from zero to the terminal value. A single-bit wrap flag is raised while the count sits at its wrap point. A parameterised prescaler sets how many input clocks make one advance. A hold input freezes both the count and the prescaler.

The clear input has three sensitivity variants, chosen at elaboration:
- level-high
- level-low
- any transition, seen through a two-stage registered copy of the input

At power-on the count starts at the terminal value. A runtime clear loads either zero or the terminal value, as a parameter selects. Every clear is applied on the clock edge.

Top module: `term_wrap_counter`

## Requirements
- R1: At power-on, before any clock edge, `cnt_o` equals TERM and the prescaler phase is zero. With DIVIDE = 3, the first advance therefore occurs at the third clock edge.
- R2: While `up_i` = 0, each advance decrements `cnt_o` by one. An advance taken at a count of zero loads TERM.
- R3: While `up_i` = 1, each advance increments `cnt_o` by one. An advance taken at a count of TERM (or above) loads zero.
- R4: `wrap_o` is combinational. It equals (`cnt_o` == 0) while `up_i` = 0 and (`cnt_o` == TERM) while `up_i` = 1, and it follows a change of `up_i` in the same cycle with no clock edge.
- R5: A runtime clear loads zero when LOAD = LOAD_ZERO and TERM when LOAD = LOAD_TERM.
- R6: With SENSE = SENSE_HIGH, every clock edge at which `rst_i` = 1 applies a clear.
- R7: With SENSE = SENSE_LOW, every clock edge at which `rst_i` = 0 applies a clear.
- R8: With SENSE = SENSE_EDGE, each transition of `rst_i` applies exactly one clear, at the second rising edge after the change. A steady level of either value applies none.
- R9: The count advances once per DIVIDE clock edges at which `hold_i` = 0 and no clear applies. With DIVIDE = 1 it advances at every such edge.
- R10: At a clock edge with `hold_i` = 1 and no clear, neither `cnt_o` nor the prescaler phase changes. A clear still applies while `hold_i` = 1.
- R11: A clear resets the prescaler phase to zero, so the next advance comes DIVIDE unheld edges after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Runtime clear; how it is interpreted is set by SENSE |
| up_i | input | 1 | Count direction: 1 counts up, 0 counts down |
| hold_i | input | 1 | Freezes the count and the prescaler while high |
| cnt_o | output | WIDTH | Current count value |
| wrap_o | output | 1 | Wrap flag for the current direction |

## Verification
The bench drives three configurations, one per clear sensitivity, with different dividers, load values and terminals. It compares every cycle against an arithmetic model.

- **Prescaler after clear:** a clear that leaves the prescaler phase stale would show up as an advance arriving early.
- **Hold during clear:** hold taking priority over clear would let a clear be lost.
- **Edge sensitivity:** an edge-sensitive variant that acts on the level would clear repeatedly while the input sits high or low.
- **Wrap flag:** the flag is checked both before and after a direction change in the same cycle. A registered flag, or one decoded from the wrong end of the range, fails there.
- **Start-up value:** a counter that starts at zero instead of TERM fails the first check.

// File: rtl/wc_pkg.sv
package wc_pkg;

   // How the runtime clear input is interpreted.
   typedef enum logic [1:0] {
      SENSE_HIGH = 2'd0,   // clear at every edge while input is high
      SENSE_LOW  = 2'd1,   // clear at every edge while input is low
      SENSE_EDGE = 2'd2    // one clear per transition of the input
   } wc_sense_e;

   // Value written into the count by a runtime clear.
   typedef enum logic {
      LOAD_ZERO = 1'b0,
      LOAD_TERM = 1'b1
   } wc_load_e;

endpackage

// File: rtl/wc_reset_sense.sv
module wc_reset_sense
   import wc_pkg::*;
#(
   parameter wc_sense_e SENSE = SENSE_HIGH
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic clr_o
);

   generate
      if (SENSE == SENSE_HIGH) begin : g_high
         logic unused_clk;
         assign unused_clk = clk_i;
         assign clr_o = rst_i;
      end else if (SENSE == SENSE_LOW) begin : g_low
         logic unused_clk;
         assign unused_clk = clk_i;
         assign clr_o = ~rst_i;
      end else begin : g_edge
         // Two-stage registered copy; any difference between the stages
         // marks one cycle in which a clear is requested.
         logic stage1_q = 1'b0;
         logic stage2_q = 1'b0;
         always_ff @(posedge clk_i) begin
            stage1_q <= rst_i;
            stage2_q <= stage1_q;
         end
         assign clr_o = stage1_q ^ stage2_q;
      end
   endgenerate

endmodule

// File: rtl/wc_prescale.sv
module wc_prescale #(
   parameter int unsigned DIVIDE = 1
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic hold_i,
   output logic step_o
);

   localparam int unsigned PW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIVIDE - 1);

   generate
      if (DIVIDE == 1) begin : g_bypass
         logic unused_in;
         assign unused_in = clk_i ^ clr_i;
         assign step_o = ~hold_i;
      end else begin : g_divide
         logic [PW-1:0] phase_q = '0;
         logic          at_last;

         assign at_last = (phase_q == LAST);
         assign step_o  = at_last & ~hold_i & ~clr_i;

         always_ff @(posedge clk_i) begin
            if (clr_i) begin
               phase_q <= '0;
            end else if (!hold_i) begin
               if (at_last) phase_q <= '0;
               else         phase_q <= phase_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wc_count_core.sv
module wc_count_core
   import wc_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned TERM  = 5,
   parameter wc_load_e    LOAD  = LOAD_ZERO
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             hold_i,
   input  logic             step_i,
   input  logic             up_i,
   output logic [WIDTH-1:0] cnt_o
);

   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);

   logic [WIDTH-1:0] clear_val;
   logic [WIDTH-1:0] cnt_q = TERM_V;
   logic [WIDTH-1:0] cnt_nxt;

   generate
      if (LOAD == LOAD_TERM) begin : g_load_term
         assign clear_val = TERM_V;
      end else begin : g_load_zero
         assign clear_val = '0;
      end
   endgenerate

   always_comb begin
      cnt_nxt = cnt_q;
      if (step_i) begin
         if (up_i) begin
            if (cnt_q >= TERM_V) cnt_nxt = '0;
            else                 cnt_nxt = cnt_q + 1'b1;
         end else begin
            if (cnt_q == '0)     cnt_nxt = TERM_V;
            else                 cnt_nxt = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (clr_i)        cnt_q <= clear_val;
      else if (!hold_i) cnt_q <= cnt_nxt;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/wc_wrap_flag.sv
module wc_wrap_flag #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned TERM  = 5
) (
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             up_i,
   output logic             flag_o
);

   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);

   logic at_low;
   logic at_high;

   assign at_low  = (cnt_i == '0);
   assign at_high = (cnt_i == TERM_V);
   assign flag_o  = up_i ? at_high : at_low;

endmodule

// File: rtl/term_wrap_counter.sv
module term_wrap_counter
   import wc_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned TERM   = 5,
   parameter int unsigned DIVIDE = 1,
   parameter wc_sense_e   SENSE  = SENSE_HIGH,
   parameter wc_load_e    LOAD   = LOAD_ZERO
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             up_i,
   input  logic             hold_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             wrap_o
);

   localparam longint unsigned CNT_MAX = (64'd1 << WIDTH) - 64'd1;

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("term_wrap_counter: WIDTH must lie in 2..32");
      end
      if (TERM == 0 || longint'(TERM) > CNT_MAX) begin : g_bad_term
         $error("term_wrap_counter: TERM must be nonzero and fit in WIDTH");
      end
      if (DIVIDE < 1) begin : g_bad_div
         $error("term_wrap_counter: DIVIDE must be at least 1");
      end
   endgenerate

   logic clr_w;
   logic step_w;

   wc_reset_sense #(.SENSE(SENSE)) u_sense (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .clr_o (clr_w)
   );

   wc_prescale #(.DIVIDE(DIVIDE)) u_pre (
      .clk_i  (clk_i),
      .clr_i  (clr_w),
      .hold_i (hold_i),
      .step_o (step_w)
   );

   wc_count_core #(.WIDTH(WIDTH), .TERM(TERM), .LOAD(LOAD)) u_core (
      .clk_i  (clk_i),
      .clr_i  (clr_w),
      .hold_i (hold_i),
      .step_i (step_w),
      .up_i   (up_i),
      .cnt_o  (cnt_o)
   );

   wc_wrap_flag #(.WIDTH(WIDTH), .TERM(TERM)) u_flag (
      .cnt_i  (cnt_o),
      .up_i   (up_i),
      .flag_o (wrap_o)
   );

endmodule

// File: rtl/wc_checker.sv
module wc_checker
   import wc_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned TERM  = 5,
   parameter wc_load_e    LOAD  = LOAD_ZERO
) (
   input logic             clk_i,
   input logic             clr_i,
   input logic             hold_i,
   input logic             up_i,
   input logic             step_i,
   input logic [WIDTH-1:0] cnt_i,
   input logic             wrap_i
);

   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);
   localparam logic [WIDTH-1:0] LOAD_V = (LOAD == LOAD_TERM) ? TERM_V : '0;

   logic live_q = 1'b0;
   always_ff @(posedge clk_i) live_q <= 1'b1;

   AST_CLEAR_LOADS: assert property (@(posedge clk_i) disable iff (!live_q)
      clr_i |=> (cnt_i == LOAD_V));                                        // R5

   AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (!live_q)
      (hold_i && !clr_i) |=> (cnt_i == $past(cnt_i)));                     // R10

   AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!live_q)
      hold_i |-> !step_i);                                                 // R10

   AST_DOWN_DECR: assert property (@(posedge clk_i) disable iff (!live_q)
      (!clr_i && step_i && !up_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) - 1'b1)); // R2

   AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!live_q)
      (!clr_i && step_i && !up_i && cnt_i == '0) |=> (cnt_i == TERM_V));   // R2

   AST_UP_RELOAD: assert property (@(posedge clk_i) disable iff (!live_q)
      (!clr_i && step_i && up_i && cnt_i == TERM_V) |=> (cnt_i == '0));    // R3

   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!live_q)
      (!clr_i && !step_i) |=> $stable(cnt_i));                             // R9

   AST_FLAG_DOWN: assert property (@(posedge clk_i) disable iff (!live_q)
      !up_i |-> (wrap_i == (cnt_i == '0)));                                // R4

   AST_NO_OVERRANGE: assert property (@(posedge clk_i) disable iff (!live_q)
      cnt_i <= TERM_V);                                                    // R3

endmodule

bind term_wrap_counter wc_checker #(.WIDTH(WIDTH), .TERM(TERM), .LOAD(LOAD)) u_chk (
   .clk_i  (clk_i),
   .clr_i  (clr_w),
   .hold_i (hold_i),
   .up_i   (up_i),
   .step_i (step_w),
   .cnt_i  (cnt_o),
   .wrap_i (wrap_o)
);

// File: tb/term_wrap_counter_bench.sv
module term_wrap_counter_bench;
   import wc_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NCYC       = 2400;

   // Three configurations: index 0 level-high, 1 level-low, 2 edge.
   localparam int TERMS [3] = '{5, 4, 6};
   localparam int DIVS  [3] = '{1, 3, 2};
   localparam int LOADT [3] = '{0, 1, 0};

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [2:0] rst_v  = 3'b010;
   logic [2:0] up_v   = 3'b000;
   logic [2:0] hold_v = 3'b000;
   logic [3:0] cnt_a, cnt_b;
   logic [2:0] cnt_c;
   logic       wrap_a, wrap_b, wrap_c;

   term_wrap_counter #(.WIDTH(4), .TERM(5), .DIVIDE(1), .SENSE(SENSE_HIGH), .LOAD(LOAD_ZERO))
   u_term_wrap_counter (.clk_i(clk), .rst_i(rst_v[0]), .up_i(up_v[0]), .hold_i(hold_v[0]),
                        .cnt_o(cnt_a), .wrap_o(wrap_a));

   term_wrap_counter #(.WIDTH(4), .TERM(4), .DIVIDE(3), .SENSE(SENSE_LOW), .LOAD(LOAD_TERM))
   u_term_wrap_counter_b (.clk_i(clk), .rst_i(rst_v[1]), .up_i(up_v[1]), .hold_i(hold_v[1]),
                          .cnt_o(cnt_b), .wrap_o(wrap_b));

   term_wrap_counter #(.WIDTH(3), .TERM(6), .DIVIDE(2), .SENSE(SENSE_EDGE), .LOAD(LOAD_ZERO))
   u_term_wrap_counter_c (.clk_i(clk), .rst_i(rst_v[2]), .up_i(up_v[2]), .hold_i(hold_v[2]),
                          .cnt_o(cnt_c), .wrap_o(wrap_c));

   int    m_cnt [3];
   int    m_div [3];
   bit    m_r1  [3];
   bit    m_r2  [3];
   bit    m_pclr[3];
   string m_tag [3];
   int    total = 0;
   int    bad   = 0;
   bit    done  = 1'b0;
   logic [31:0] rng = 32'h1234_5678;

   function automatic int dut_cnt(int i);
      if (i == 0) return int'(cnt_a);
      if (i == 1) return int'(cnt_b);
      return int'(cnt_c);
   endfunction

   function automatic int dut_wrap(int i);
      if (i == 0) return int'(wrap_a);
      if (i == 1) return int'(wrap_b);
      return int'(wrap_c);
   endfunction

   task automatic check(string req, int i, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s inst%0d %s actual=%0d expected=%0d t=%0t", req, i, what, act, exp, $time);
      end
   endtask

   task automatic check_flag(int i);
      int exp;
      exp = up_v[i] ? int'(m_cnt[i] == TERMS[i]) : int'(m_cnt[i] == 0);
      check("R4", i, "wrap", dut_wrap(i), exp);
   endtask

   // Arithmetic model of one clock edge for configuration i.
   task automatic step_model(int i);
      bit clr;
      bit adv;
      if (i == 0)      clr = rst_v[0];
      else if (i == 1) clr = !rst_v[1];
      else begin
         clr = m_r1[i] ^ m_r2[i];
         m_r2[i] = m_r1[i];
         m_r1[i] = rst_v[i];
      end
      if (clr) begin
         m_cnt[i]  = (LOADT[i] != 0) ? TERMS[i] : 0;
         m_div[i]  = 0;
         m_pclr[i] = 1'b1;
         m_tag[i]  = (i == 0) ? "R6" : (i == 1) ? "R7 R5" : "R8";
      end else if (hold_v[i]) begin
         m_tag[i] = "R10";
      end else begin
         adv = (m_div[i] == DIVS[i] - 1);
         m_div[i] = adv ? 0 : m_div[i] + 1;
         if (adv) begin
            if (up_v[i]) m_cnt[i] = (m_cnt[i] >= TERMS[i]) ? 0 : m_cnt[i] + 1;
            else         m_cnt[i] = (m_cnt[i] == 0) ? TERMS[i] : m_cnt[i] - 1;
            m_tag[i]  = m_pclr[i] ? "R11" : (up_v[i] ? "R3" : "R2");
            m_pclr[i] = 1'b0;
         end else begin
            m_tag[i] = "R9";
         end
      end
   endtask

   task automatic next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin
         m_cnt[i] = TERMS[i]; m_div[i] = 0;
         m_r1[i] = 1'b0; m_r2[i] = 1'b0; m_pclr[i] = 1'b0;
         m_tag[i] = "R1";
      end
      #1;
      for (int i = 0; i < 3; i++) begin
         check("R1", i, "power-on count", dut_cnt(i), TERMS[i]);
         check("R1", i, "power-on wrap", dut_wrap(i), 0);
      end
      up_v = 3'b111;
      #1;
      for (int i = 0; i < 3; i++) check("R4", i, "wrap at TERM counting up", dut_wrap(i), 1);
      up_v = 3'b000;
      #1;
      for (int i = 0; i < 3; i++) step_model(i);

      for (int cyc = 0; cyc < NCYC; cyc++) begin
         @(negedge clk);
         for (int i = 0; i < 3; i++) begin
            check(m_tag[i], i, "count", dut_cnt(i), m_cnt[i]);
            check_flag(i);
         end
         next_rng();
         if (cyc < 60)       up_v = 3'b000;
         else if (cyc < 120) up_v = 3'b111;
         else if (rng[2:0] == 3'd0) up_v = ~up_v;
         hold_v = (cyc < 120) ? 3'b000 : {rng[4:3] == 2'd0, rng[6:5] == 2'd0, rng[8:7] == 2'd0};
         if (cyc >= 180) begin
            rst_v[0] = (rng[11:9] == 3'd0);
            rst_v[1] = !(rng[14:12] == 3'd0);
            if (rng[17:15] == 3'd0) rst_v[2] = ~rst_v[2];
         end
         #1;
         for (int i = 0; i < 3; i++) check_flag(i);
         for (int i = 0; i < 3; i++) step_model(i);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * (NCYC + 1000));
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired t=%0t", $time);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule